// File: doc/BRIEF.md
# Three-Level PWM Input Classifier

This block turns a stream of digitised PWM pin voltages into one of three pin states: driven high, driven low, or released into the middle band, which means the controller has stopped driving the pin. Each sample is a millivolt code that comes with a valid strobe. High and low decisions act on the first valid sample that crosses the outer thresholds. A move into the middle band is reported only after the input has stayed there for a qualification time. This keeps a slow edge passing through the band from being mistaken for a released pin.

The middle band has a different inner edge depending on where the input is coming from. Coming up from low, it starts above 1300 mV. Coming down from high, it starts below 1800 mV. Outside the band, the current state is simply kept. The registered state code feeds a gate-drive sequencer. A one-cycle strobe marks every change of state. All thresholds and the qualification time are parameters.

Top module: `pwm_tri_decoder`

## Requirements
- R1: The state output uses the code 2'b00 for low, 2'b01 for high and 2'b10 for middle band (released); the code 2'b11 never appears.
- R2: A valid sample above HI_RISE_MV (default 2000) sets the state to high at the next clock edge, from any state.
- R3: A valid sample below LO_FALL_MV (default 1000) sets the state to low at the next clock edge, from any state.
- R4: While low, only samples above MID_FROM_LO_MV (default 1300) count as in-band. While high, only samples below MID_FROM_HI_MV (default 1800) count as in-band. Any other sample between the outer thresholds keeps the state.
- R5: The state becomes middle band only on the HOLD_CYCLES-th consecutive valid in-band sample. HOLD_CYCLES is ceil(HOLDOFF_PS / CLK_PERIOD_PS), which is 19 by default. Until then, the earlier high or low state is held.
- R6: A valid sample that is not in-band restarts the qualification count from zero. Cycles with the valid strobe low neither advance nor clear the count.
- R7: In the middle-band state, the state is kept for every sample from LO_FALL_MV to HI_RISE_MV inclusive. Only R2 or R3 leaves it.
- R8: Reset, which is asynchronous and active low, forces the middle-band state with the strobe low. The state stays there until a valid sample satisfies R2 or R3.
- R9: The change strobe is high for exactly the one cycle in which the state output shows a new value, and is low otherwise.
- R10: A sample presented with the valid strobe low has no effect on the state.
- R11: 3.3 V logic levels are accepted: a sample of 3300 mV gives high and a sample of 0 mV gives low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; smp_mv is used only when high |
| smp_mv | input | SAMPLE_W | Pin voltage in millivolts, unsigned |
| state_o | output | 2 | Registered pin state code (R1) |
| change_o | output | 1 | One-cycle strobe on each state change |

## Verification
A qualification count that is wrong shows up as the released state appearing one or more samples early or late. It can also show up as a state that never appears after a run of in-band samples that was interrupted. It becomes visible at the port on the edge after the deciding sample. A wrong state register shows up on the next valid sample as a wrong hysteresis decision: the band may be entered from the wrong side, or an edge may be missed. The change strobe exposes any silent state flip within the same cycle.

// File: rtl/pwm_tri_pkg.sv
package pwm_tri_pkg;

  typedef enum logic [1:0] {
    PS_LOW  = 2'b00,
    PS_HIGH = 2'b01,
    PS_TRI  = 2'b10
  } pin_state_e;

  typedef enum logic [1:0] {
    LV_KEEP    = 2'b00,
    LV_TO_HIGH = 2'b01,
    LV_TO_LOW  = 2'b10,
    LV_BAND    = 2'b11
  } level_e;

endpackage

// File: rtl/pwm_level_classify.sv
module pwm_level_classify
  import pwm_tri_pkg::*;
#(
  parameter int SAMPLE_W       = 12,
  parameter int HI_RISE_MV     = 2000,
  parameter int LO_FALL_MV     = 1000,
  parameter int MID_FROM_LO_MV = 1300,
  parameter int MID_FROM_HI_MV = 1800
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  pin_state_e          cur_state,
  output level_e              level
);

  localparam logic [SAMPLE_W-1:0] HiV    = SAMPLE_W'(HI_RISE_MV);
  localparam logic [SAMPLE_W-1:0] LoV    = SAMPLE_W'(LO_FALL_MV);
  localparam logic [SAMPLE_W-1:0] MidLoV = SAMPLE_W'(MID_FROM_LO_MV);
  localparam logic [SAMPLE_W-1:0] MidHiV = SAMPLE_W'(MID_FROM_HI_MV);

  always_comb begin
    level = LV_KEEP;
    if (sample > HiV) begin
      level = LV_TO_HIGH;
    end else if (sample < LoV) begin
      level = LV_TO_LOW;
    end else begin
      unique case (cur_state)
        PS_LOW:  level = (sample > MidLoV) ? LV_BAND : LV_KEEP;
        PS_HIGH: level = (sample < MidHiV) ? LV_BAND : LV_KEEP;
        default: level = LV_KEEP;
      endcase
    end
  end

endmodule

// File: rtl/pwm_holdoff_timer.sv
module pwm_holdoff_timer #(
  parameter int HOLD_CYCLES = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic expire
);

  localparam int CntW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CntW-1:0] Last = CntW'(HOLD_CYCLES - 1);

  logic [CntW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign expire = step && (cnt_q == Last);
  assign cnt_en = step || clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || expire) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R5: the count never passes the qualification limit
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= Last);

  // R6: an out-of-band sample restarts the count
  a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_tri_decoder.sv
module pwm_tri_decoder
  import pwm_tri_pkg::*;
#(
  parameter int SAMPLE_W       = 12,
  parameter int HI_RISE_MV     = 2000,
  parameter int LO_FALL_MV     = 1000,
  parameter int MID_FROM_LO_MV = 1300,
  parameter int MID_FROM_HI_MV = 1800,
  parameter int CLK_PERIOD_PS  = 8000,
  parameter int HOLDOFF_PS     = 150000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_mv,
  output logic [1:0]          state_o,
  output logic                change_o
);

  localparam int HoldRaw    = (HOLDOFF_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int HoldCycles = (HoldRaw < 1) ? 1 : HoldRaw;
  localparam logic [SAMPLE_W-1:0] HiV = SAMPLE_W'(HI_RISE_MV);
  localparam logic [SAMPLE_W-1:0] LoV = SAMPLE_W'(LO_FALL_MV);

  pin_state_e state_q, state_d;
  logic       change_q, change_d;
  level_e     level;
  logic       in_band, expire;

  pwm_level_classify #(
    .SAMPLE_W      (SAMPLE_W),
    .HI_RISE_MV    (HI_RISE_MV),
    .LO_FALL_MV    (LO_FALL_MV),
    .MID_FROM_LO_MV(MID_FROM_LO_MV),
    .MID_FROM_HI_MV(MID_FROM_HI_MV)
  ) i_classify (
    .sample   (smp_mv),
    .cur_state(state_q),
    .level    (level)
  );

  assign in_band = (level == LV_BAND);

  pwm_holdoff_timer #(
    .HOLD_CYCLES(HoldCycles)
  ) i_holdoff (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (smp_valid && in_band),
    .clear (smp_valid && !in_band),
    .expire(expire)
  );

  always_comb begin
    state_d = state_q;
    if (smp_valid) begin
      unique case (level)
        LV_TO_HIGH: state_d = PS_HIGH;
        LV_TO_LOW:  state_d = PS_LOW;
        LV_BAND:    if (expire) state_d = PS_TRI;
        default:    state_d = state_q;
      endcase
    end
    change_d = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_TRI;
      change_q <= 1'b0;
    end else begin
      if (smp_valid) begin
        state_q <= state_d;
      end
      change_q <= change_d;
    end
  end

  assign state_o  = state_q;
  assign change_o = change_q;

  // R1: the unused code never leaves the block
  a_r1_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);

  // R2: a high sample acts on the next edge
  a_r2_high_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_mv > HiV)) |=> (state_o == PS_HIGH));

  // R3: a low sample acts on the next edge
  a_r3_low_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_mv < LoV)) |=> (state_o == PS_LOW));

  // R5: the released state is only entered on a valid sample
  a_r5_tri_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == PS_TRI) && ($past(state_o) != PS_TRI)) |-> $past(smp_valid));

  // R9: the strobe marks exactly the cycles with a new state
  a_r9_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    change_o == (state_o != $past(state_o)));

  // R10: an invalid sample leaves the state untouched
  a_r10_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(state_o));

endmodule

// File: tb/test_pwm_tri_decoder.sv
`timescale 1ns/1ps
module test_pwm_tri_decoder;

  localparam int SW   = 12;
  localparam int HOLD = 19;   // ceil(150000 / 8000)
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, TR = 2'b10;

  // each entry: millivolts, valid samples applied, expected state afterwards
  localparam int NV = 18;
  localparam int VEC [NV][3] = '{
    '{3300, 1,        1},  // R11 R2
    '{1900, 5,        1},  // R4 above high-side band edge
    '{1700, HOLD - 1, 1},  // R5 not yet qualified
    '{1700, 1,        2},  // R5 qualified
    '{1500, 3,        2},  // R7
    '{ 900, 1,        0},  // R3
    '{1200, 30,       0},  // R4 below low-side band edge
    '{1400, 10,       0},  // R5 counting
    '{1100, 1,        0},  // R6 restart
    '{1400, HOLD - 1, 0},  // R6 restarted count
    '{1400, 1,        2},  // R5
    '{2100, 1,        1},  // R2 R7
    '{   0, 1,        0},  // R11 R3
    '{1999, 2,        0},  // R4
    '{2000, 1,        0},  // R2 boundary not above
    '{2001, 1,        1},  // R2 boundary
    '{1000, 1,        1},  // R3 boundary not below
    '{ 999, 1,        0}   // R3
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [SW-1:0] smp_mv;
  logic [1:0]    state_o;
  logic          change_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  pwm_tri_decoder #(
    .SAMPLE_W(SW), .HI_RISE_MV(2000), .LO_FALL_MV(1000),
    .MID_FROM_LO_MV(1300), .MID_FROM_HI_MV(1800),
    .CLK_PERIOD_PS(8000), .HOLDOFF_PS(150000)
  ) i_pwm_tri_decoder (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .state_o(state_o), .change_o(change_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input int mv, input logic vld, input int n);
    smp_mv    = SW'(mv);
    smp_valid = vld;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_mv = '0;
    repeat (3) @(negedge clk);
    check("R8 reset state", state_o, TR);
    check("R8 reset strobe", change_o, 0);
    rst_n = 1'b1;
    apply(3300, 1'b0, 3);
    check("R10 invalid after reset", state_o, TR);
    apply(1500, 1'b1, HOLD + 2);
    check("R8 held until high or low", state_o, TR);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0], 1'b1, VEC[i][1]);
      check($sformatf("R1 R4 R5 vector %0d", i), state_o, VEC[i][2]);
    end

    // R10: invalid samples ignored while low
    apply(3300, 1'b0, 5);
    check("R10 invalid ignored", state_o, LO);
    check("R9 no strobe when idle", change_o, 0);

    // R9: strobe exactly one cycle
    apply(3300, 1'b1, 1);
    check("R9 high taken", state_o, HI);
    check("R9 strobe set", change_o, 1);
    apply(3300, 1'b1, 1);
    check("R9 strobe single cycle", change_o, 0);

    // R6: gaps in valid neither advance nor clear the count
    apply(1700, 1'b1, 10);
    apply(1700, 1'b0, 5);
    check("R6 gap holds state", state_o, HI);
    apply(1700, 1'b1, HOLD - 11);
    check("R6 one short", state_o, HI);
    apply(1700, 1'b1, 1);
    check("R6 count kept over gap", state_o, TR);
    check("R9 strobe on release", change_o, 1);

    // R8: asynchronous reset mid-run
    apply(0, 1'b1, 1);
    check("R3 low before reset", state_o, LO);
    #1 rst_n = 1'b0;
    #1;
    check("R8 async reset", state_o, TR);
    @(negedge clk);
    rst_n = 1'b1;
    apply(0, 1'b1, 1);
    check("R11 zero is low", state_o, LO);

    finish_run();
  end

endmodule